// File: doc/BRIEF.md
# Interrupt controller command sequencer

This block is the byte-wide register front end of a single eight-line interrupt controller. Software talks to it through two addresses with one-cycle write and read strobes. Through them it runs the multi-word initialisation sequence, issues operation commands and reads back controller state. The operation commands cover end-of-interrupt in its specific, non-specific and rotating forms, setting the priority offset, arming a poll and selecting which register a read returns. The block holds the mask, in-service and rotation state and the mode bits. It contains its own edge-sensing request latch and a rotating priority resolver.

The processor side raises an acknowledge strobe when it takes the interrupt. The block then records the winning line as in service and returns the vector, which is the programmed base plus the line number. With automatic end-of-interrupt enabled, acknowledge releases the line again at once, and it can optionally rotate priority at the same time. A poll read serves the highest request with no acknowledge cycle. Strobes are expected one at a time. If several arrive in the same cycle, the write is taken first, then the read, then the acknowledge, and the others are dropped.

Top module: `intc_cmd_seq`

## Requirements
- R1: After reset the mask (IMR), in-service (ISR) and request (IRR) registers are zero, the priority offset is 0, read-select points at IRR, the block is in normal mode, int_req is low, and rdata and ack_vec read 0.
- R2: A rising level on an irq_in line sets its IRR bit at the next clock edge. Each line has a rank of (line − offset) mod 8, where rank 0 is the highest priority. int_req is high exactly when the best unmasked request has a strictly better rank than the best in-service line, taken after the exclusions of R11 and R12.
- R3: A write to address 0 with data bit 4 set starts initialisation. Bit 0 of that write says whether a fourth word follows. The write clears IMR, offset, special mask and read-select, and it also clears nested mode and auto-EOI when bit 0 is 0. The next address-1 write sets the vector base to data AND 0xF8. The one after it is ignored. A fourth word, if announced, sets nested mode from bit 4 and auto-EOI from bit 1. The block then returns to normal mode.
- R4: In normal mode, an address-1 write loads IMR and a non-poll read of address 1 returns IMR. A masked line keeps its IRR bit but does not raise int_req.
- R5: An address-0 write with bit 4 = 0 and bit 3 = 1 is a read/poll command. If bit 1 is set, bit 0 picks what a non-poll address-0 read returns: 1 gives ISR, 0 gives IRR. rdata is registered and is valid from the clock edge that samples rd_en.
- R6: On ack with a request winning, that line's ISR bit is set and its IRR bit is cleared, and ack_vec becomes base + line. With no winner, ack_vec becomes base + 7 and no state changes.
- R7: With auto-EOI on, the ISR bit set by ack is cleared again. Command code 4 (data bits 7:5, bits 4:3 = 0) enables rotate-on-auto-EOI and code 0 disables it. While it is enabled, each acknowledged line sets the offset to line + 1.
- R8: Code 1 clears the best-ranked ISR bit. Code 5 does the same and also sets the offset to that line + 1.
- R9: Code 3 clears ISR bit (data AND 7). Code 7 does the same and sets the offset to that line + 1. Code 6 sets the offset to (data + 1) mod 8. Code 2 changes nothing.
- R10: Bit 2 of a read/poll command arms poll. The next read returns the winning line number and clears that line's IRR and ISR bits, or it returns 7 if no request wins. That read disarms poll, so the read after it is a normal register read.
- R11: Bit 6 of a read/poll command enables loading of the special-mask flag from bit 5. While the flag is set, in-service lines that are masked in IMR do not block other requests.
- R12: While nested mode is on, the in-service bit of line NEST_LINE (default 2) is left out of the comparison in R2, so a new request on that same line wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt request lines, edge sensed |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 1 | Register address (0 or 1) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ack | input | 1 | One-cycle interrupt acknowledge strobe |
| ack_vec | output | 8 | Registered vector from the last acknowledge |
| int_req | output | 1 | Interrupt request to the processor |

## Verification
The checker watches several rules on every cycle. int_req never rises without an unmasked IRR bit behind it. An init write always leaves the mask and offset at zero, and a normal-mode address-1 write loads the mask. A poll read always disarms poll. An auto-EOI acknowledge leaves ISR unchanged, and ISR never gains more than one bit in a cycle. Other behaviour only shows in the bench's ordered scenarios. This includes the exact vectors returned under a rotated priority order, which line a non-specific EOI clears, the effect of the special mask and nested mode on int_req, and the values poll reads return.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    IS_NORM = 2'd0,
    IS_W2   = 2'd1,
    IS_W3   = 2'd2,
    IS_W4   = 2'd3
  } init_st_e;

  // operation command codes (data bits 7:5 when bits 4:3 are zero)
  localparam logic [2:0] OC_ROT_CLR = 3'd0;
  localparam logic [2:0] OC_EOI     = 3'd1;
  localparam logic [2:0] OC_NOP     = 3'd2;
  localparam logic [2:0] OC_SEOI    = 3'd3;
  localparam logic [2:0] OC_ROT_SET = 3'd4;
  localparam logic [2:0] OC_REOI    = 3'd5;
  localparam logic [2:0] OC_SETPRI  = 3'd6;
  localparam logic [2:0] OC_RSEOI   = 3'd7;

  // bit positions in address-0 writes
  localparam int B_INIT  = 4;
  localparam int B_RDCMD = 3;
  localparam int B_POLL  = 2;
  localparam int B_RSEN  = 1;
  localparam int B_RSEL  = 0;
  localparam int B_SMEN  = 6;
  localparam int B_SMV   = 5;
  localparam int B_NEED4 = 0;
  // bit positions in the fourth init word
  localparam int B_NEST  = 4;
  localparam int B_AEOI  = 1;

endpackage

// File: rtl/intc_req_latch.sv
module intc_req_latch #(
  parameter int NL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] lines,
  input  logic [NL-1:0] clr,
  output logic [NL-1:0] irr
);

  logic [NL-1:0] prev_q, prev_n;
  logic [NL-1:0] irr_q, irr_n;

  always_comb begin
    prev_n = lines;
    irr_n  = (irr_q & ~clr) | (lines & ~prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= prev_n;
      irr_q  <= irr_n;
    end
  end

  assign irr = irr_q;

endmodule

// File: rtl/intc_prio_res.sv
module intc_prio_res #(
  parameter int NL = 8,
  parameter int LW = $clog2(NL)
) (
  input  logic [NL-1:0] req,
  input  logic [LW-1:0] off,
  output logic          any,
  output logic [LW-1:0] line
);

  logic [NL-1:0] rot;
  logic [LW-1:0] k;
  logic [LW-1:0] idx;

  // rot[i] is the request holding rank i
  always_comb begin
    k = '0;
    for (int i = 0; i < NL; i++) begin
      k      = LW'(i) + off;
      rot[i] = req[k];
    end
  end

  always_comb begin
    idx = '0;
    for (int i = NL-1; i >= 0; i--) begin
      if (rot[i]) idx = LW'(i);
    end
  end

  assign any  = |rot;
  assign line = idx + off;

endmodule

// File: rtl/intc_seq_core.sv
module intc_seq_core
  import intc_pkg::*;
#(
  parameter int NL        = 8,
  parameter int DW        = 8,
  parameter int NEST_LINE = 2,
  parameter int LW        = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic          ack,
  input  logic [DW-1:0] wdata,
  input  logic [NL-1:0] irr,
  input  logic          pend_any,
  input  logic [LW-1:0] pend_line,
  input  logic          cmp_any,
  input  logic [LW-1:0] cmp_line,
  input  logic          top_any,
  input  logic [LW-1:0] top_line,
  output logic [NL-1:0] imr,
  output logic [NL-1:0] isr,
  output logic [NL-1:0] cmp_vec,
  output logic [NL-1:0] clr,
  output logic [LW-1:0] off,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] ack_vec,
  output logic          int_req
);

  localparam int BW = DW - LW;

  logic [NL-1:0] imr_q, imr_n, isr_q, isr_n;
  logic [LW-1:0] off_q, off_n;
  logic [BW-1:0] base_q, base_n;
  logic          need4_q, need4_n;
  logic          fnm_q, fnm_n;
  logic          aeoi_q, aeoi_n;
  logic          rota_q, rota_n;
  logic          smm_q, smm_n;
  logic          rsel_q, rsel_n;
  logic          poll_q, poll_n;
  init_st_e      ist_q, ist_n;
  logic [DW-1:0] rdata_q, rdata_n, vec_q, vec_n;

  logic [LW-1:0] pend_rank, cmp_rank, sel;
  logic [NL-1:0] nest_bit;
  logic          win, upd;

  assign nest_bit  = NL'(1) << NEST_LINE;
  assign cmp_vec   = isr_q & ~(smm_q ? imr_q : '0) & ~(fnm_q ? nest_bit : '0);
  assign pend_rank = pend_line - off_q;
  assign cmp_rank  = cmp_line - off_q;
  assign win       = pend_any && (!cmp_any || (pend_rank < cmp_rank));
  assign sel       = wdata[LW-1:0];
  assign upd       = wr_en | rd_en | ack;

  always_comb begin
    imr_n   = imr_q;
    isr_n   = isr_q;
    off_n   = off_q;
    base_n  = base_q;
    need4_n = need4_q;
    fnm_n   = fnm_q;
    aeoi_n  = aeoi_q;
    rota_n  = rota_q;
    smm_n   = smm_q;
    rsel_n  = rsel_q;
    poll_n  = poll_q;
    ist_n   = ist_q;
    rdata_n = rdata_q;
    vec_n   = vec_q;
    clr     = '0;
    if (wr_en) begin
      if (!addr) begin
        if (wdata[B_INIT]) begin
          need4_n = wdata[B_NEED4];
          imr_n   = '0;
          off_n   = '0;
          smm_n   = 1'b0;
          rsel_n  = 1'b0;
          if (!wdata[B_NEED4]) begin
            fnm_n  = 1'b0;
            aeoi_n = 1'b0;
          end
          ist_n = IS_W2;
        end else if (wdata[B_RDCMD]) begin
          if (wdata[B_POLL]) poll_n = 1'b1;
          if (wdata[B_RSEN]) rsel_n = wdata[B_RSEL];
          if (wdata[B_SMEN]) smm_n = wdata[B_SMV];
        end else begin
          case (wdata[DW-1:DW-3])
            OC_ROT_CLR: rota_n = 1'b0;
            OC_ROT_SET: rota_n = 1'b1;
            OC_EOI: begin
              if (top_any) isr_n[top_line] = 1'b0;
            end
            OC_REOI: begin
              if (top_any) begin
                isr_n[top_line] = 1'b0;
                off_n           = top_line + LW'(1);
              end
            end
            OC_SEOI: isr_n[sel] = 1'b0;
            OC_SETPRI: off_n = sel + LW'(1);
            OC_RSEOI: begin
              isr_n[sel] = 1'b0;
              off_n      = sel + LW'(1);
            end
            default: ;
          endcase
        end
      end else begin
        case (ist_q)
          IS_NORM: imr_n = NL'(wdata);
          IS_W2: begin
            base_n = wdata[DW-1:LW];
            ist_n  = IS_W3;
          end
          IS_W3: ist_n = need4_q ? IS_W4 : IS_NORM;
          default: begin
            fnm_n  = wdata[B_NEST];
            aeoi_n = wdata[B_AEOI];
            ist_n  = IS_NORM;
          end
        endcase
      end
    end else if (rd_en) begin
      if (poll_q) begin
        poll_n = 1'b0;
        if (win) begin
          rdata_n          = DW'(pend_line);
          clr[pend_line]   = 1'b1;
          isr_n[pend_line] = 1'b0;
        end else begin
          rdata_n = DW'(NL - 1);
        end
      end else if (addr) begin
        rdata_n = DW'(imr_q);
      end else begin
        rdata_n = rsel_q ? DW'(isr_q) : DW'(irr);
      end
    end else if (ack) begin
      if (win) begin
        isr_n[pend_line] = 1'b1;
        clr[pend_line]   = 1'b1;
        vec_n            = {base_q, pend_line};
        if (aeoi_q) begin
          isr_n[pend_line] = 1'b0;
          if (rota_q) off_n = pend_line + LW'(1);
        end
      end else begin
        vec_n = {base_q, LW'(NL - 1)};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q   <= '0;
      isr_q   <= '0;
      off_q   <= '0;
      base_q  <= '0;
      need4_q <= 1'b0;
      fnm_q   <= 1'b0;
      aeoi_q  <= 1'b0;
      rota_q  <= 1'b0;
      smm_q   <= 1'b0;
      rsel_q  <= 1'b0;
      poll_q  <= 1'b0;
      ist_q   <= IS_NORM;
      rdata_q <= '0;
      vec_q   <= '0;
    end else if (upd) begin
      imr_q   <= imr_n;
      isr_q   <= isr_n;
      off_q   <= off_n;
      base_q  <= base_n;
      need4_q <= need4_n;
      fnm_q   <= fnm_n;
      aeoi_q  <= aeoi_n;
      rota_q  <= rota_n;
      smm_q   <= smm_n;
      rsel_q  <= rsel_n;
      poll_q  <= poll_n;
      ist_q   <= ist_n;
      rdata_q <= rdata_n;
      vec_q   <= vec_n;
    end
  end

  assign imr     = imr_q;
  assign isr     = isr_q;
  assign off     = off_q;
  assign rdata   = rdata_q;
  assign ack_vec = vec_q;
  assign int_req = win;

endmodule

// File: rtl/intc_cmd_seq.sv
module intc_cmd_seq #(
  parameter int NL        = 8,
  parameter int DW        = 8,
  parameter int NEST_LINE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] irq_in,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          ack,
  output logic [DW-1:0] ack_vec,
  output logic          int_req
);

  localparam int LW = $clog2(NL);

  logic [NL-1:0] irr, imr, isr, cmp_vec, clr;
  logic [LW-1:0] off, pend_line, cmp_line, top_line;
  logic          pend_any, cmp_any, top_any;

  intc_req_latch #(.NL(NL)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .lines (irq_in),
    .clr   (clr),
    .irr   (irr)
  );

  intc_prio_res #(.NL(NL), .LW(LW)) u_res_pend (
    .req  (irr & ~imr),
    .off  (off),
    .any  (pend_any),
    .line (pend_line)
  );

  intc_prio_res #(.NL(NL), .LW(LW)) u_res_cmp (
    .req  (cmp_vec),
    .off  (off),
    .any  (cmp_any),
    .line (cmp_line)
  );

  intc_prio_res #(.NL(NL), .LW(LW)) u_res_isr (
    .req  (isr),
    .off  (off),
    .any  (top_any),
    .line (top_line)
  );

  intc_seq_core #(.NL(NL), .DW(DW), .NEST_LINE(NEST_LINE), .LW(LW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .ack       (ack),
    .wdata     (wdata),
    .irr       (irr),
    .pend_any  (pend_any),
    .pend_line (pend_line),
    .cmp_any   (cmp_any),
    .cmp_line  (cmp_line),
    .top_any   (top_any),
    .top_line  (top_line),
    .imr       (imr),
    .isr       (isr),
    .cmp_vec   (cmp_vec),
    .clr       (clr),
    .off       (off),
    .rdata     (rdata),
    .ack_vec   (ack_vec),
    .int_req   (int_req)
  );

endmodule

// File: rtl/intc_cmd_seq_chk.sv
module intc_cmd_seq_chk
  import intc_pkg::*;
#(
  parameter int NL = 8,
  parameter int DW = 8,
  parameter int LW = $clog2(NL)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          ack,
  input logic          addr,
  input logic [DW-1:0] wdata,
  input logic [NL-1:0] irr,
  input logic [NL-1:0] imr,
  input logic [NL-1:0] isr,
  input logic [LW-1:0] off,
  input logic          aeoi,
  input logic          poll,
  input logic [1:0]    ist,
  input logic          int_req
);

  a_r2_req_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((irr & ~imr) != '0));

  a_r3_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[B_INIT]) |=> (imr == '0 && off == '0));

  a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && ist == IS_NORM) |=> (imr == NL'($past(wdata))));

  a_r10_poll_once: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && poll) |=> !poll);

  a_r7_aeoi_isr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr_en && !rd_en && aeoi) |=> (isr == $past(isr)));

  a_r6_one_new_isr: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr & ~$past(isr)));

endmodule

bind intc_seq_core intc_cmd_seq_chk #(.NL(NL), .DW(DW), .LW(LW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .ack     (ack),
  .addr    (addr),
  .wdata   (wdata),
  .irr     (irr),
  .imr     (imr_q),
  .isr     (isr_q),
  .off     (off_q),
  .aeoi    (aeoi_q),
  .poll    (poll_q),
  .ist     (ist_q),
  .int_req (int_req)
);

// File: tb/sim_intc_cmd_seq.sv
module sim_intc_cmd_seq;

  localparam logic [2:0] OP_IRQ = 3'd0;
  localparam logic [2:0] OP_WR0 = 3'd1;
  localparam logic [2:0] OP_WR1 = 3'd2;
  localparam logic [2:0] OP_RD0 = 3'd3;
  localparam logic [2:0] OP_RD1 = 3'd4;
  localparam logic [2:0] OP_ACK = 3'd5;
  localparam logic [2:0] OP_CHK = 3'd6;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] d;
    logic [7:0] e;
    logic [3:0] r;
  } vec_t;

  localparam int NV = 64;
  localparam vec_t TBL [NV] = '{
    '{OP_WR1, 8'h5A, 8'h00, 4'd4},  // R4 load mask after reset
    '{OP_RD1, 8'h00, 8'h5A, 4'd4},  // R4 mask readback
    '{OP_WR0, 8'h11, 8'h00, 4'd3},  // R3 init, fourth word follows
    '{OP_WR1, 8'h20, 8'h00, 4'd3},  // R3 base 0x20
    '{OP_WR1, 8'h00, 8'h00, 4'd3},  // R3 third word ignored
    '{OP_WR1, 8'h00, 8'h00, 4'd3},  // R3 fourth word
    '{OP_RD1, 8'h00, 8'h00, 4'd3},  // R3 mask cleared by init
    '{OP_IRQ, 8'h08, 8'h00, 4'd2},  // R2 line 3 rises
    '{OP_CHK, 8'h00, 8'h01, 4'd2},
    '{OP_RD0, 8'h00, 8'h08, 4'd5},  // R5 IRR selected
    '{OP_ACK, 8'h00, 8'h23, 4'd6},  // R6 vector base+3
    '{OP_CHK, 8'h00, 8'h00, 4'd6},
    '{OP_WR0, 8'h0B, 8'h00, 4'd5},  // R5 select ISR
    '{OP_RD0, 8'h00, 8'h08, 4'd5},
    '{OP_IRQ, 8'h0C, 8'h00, 4'd2},  // R2 line 2 outranks in-service 3
    '{OP_CHK, 8'h00, 8'h01, 4'd2},
    '{OP_IRQ, 8'h2C, 8'h00, 4'd2},
    '{OP_ACK, 8'h00, 8'h22, 4'd6},
    '{OP_CHK, 8'h00, 8'h00, 4'd2},  // R2 line 5 blocked
    '{OP_WR0, 8'h20, 8'h00, 4'd8},  // R8 non-specific EOI
    '{OP_RD0, 8'h00, 8'h08, 4'd8},
    '{OP_CHK, 8'h00, 8'h00, 4'd8},
    '{OP_WR0, 8'h63, 8'h00, 4'd9},  // R9 specific EOI line 3
    '{OP_RD0, 8'h00, 8'h00, 4'd9},
    '{OP_CHK, 8'h00, 8'h01, 4'd9},
    '{OP_WR0, 8'h0A, 8'h00, 4'd5},  // R5 select IRR
    '{OP_RD0, 8'h00, 8'h20, 4'd5},
    '{OP_WR0, 8'hC5, 8'h00, 4'd9},  // R9 set offset to 6
    '{OP_ACK, 8'h00, 8'h25, 4'd9},
    '{OP_IRQ, 8'h2D, 8'h00, 4'd9},  // line 0 outranks 5 under offset 6
    '{OP_CHK, 8'h00, 8'h01, 4'd9},
    '{OP_ACK, 8'h00, 8'h20, 4'd9},
    '{OP_WR0, 8'hA0, 8'h00, 4'd8},  // R8 rotating EOI clears line 0
    '{OP_WR0, 8'h0B, 8'h00, 4'd8},
    '{OP_RD0, 8'h00, 8'h20, 4'd8},
    '{OP_WR0, 8'hE5, 8'h00, 4'd9},  // R9 specific rotate line 5
    '{OP_RD0, 8'h00, 8'h00, 4'd9},
    '{OP_WR0, 8'h40, 8'h00, 4'd9},  // R9 code 2 no-op
    '{OP_RD0, 8'h00, 8'h00, 4'd9},
    '{OP_IRQ, 8'h00, 8'h00, 4'd10},
    '{OP_IRQ, 8'h10, 8'h00, 4'd10},
    '{OP_WR0, 8'h0C, 8'h00, 4'd10}, // R10 arm poll
    '{OP_RD1, 8'h00, 8'h04, 4'd10},
    '{OP_RD0, 8'h00, 8'h00, 4'd10}, // R10 poll disarmed, ISR read
    '{OP_WR0, 8'h0A, 8'h00, 4'd10},
    '{OP_RD0, 8'h00, 8'h00, 4'd10}, // R10 IRR cleared by poll
    '{OP_WR0, 8'h0C, 8'h00, 4'd10},
    '{OP_RD0, 8'h00, 8'h07, 4'd10}, // R10 empty poll
    '{OP_CHK, 8'h00, 8'h00, 4'd10},
    '{OP_IRQ, 8'h00, 8'h00, 4'd4},
    '{OP_WR1, 8'h01, 8'h00, 4'd4},  // R4 mask line 0
    '{OP_IRQ, 8'h01, 8'h00, 4'd4},
    '{OP_CHK, 8'h00, 8'h00, 4'd4},
    '{OP_RD0, 8'h00, 8'h01, 4'd4},
    '{OP_WR1, 8'h00, 8'h00, 4'd4},
    '{OP_CHK, 8'h00, 8'h01, 4'd4},
    '{OP_ACK, 8'h00, 8'h20, 4'd6},
    '{OP_WR1, 8'h01, 8'h00, 4'd11},
    '{OP_IRQ, 8'h03, 8'h00, 4'd11},
    '{OP_CHK, 8'h00, 8'h00, 4'd11}, // R11 in-service 0 blocks 1
    '{OP_WR0, 8'h68, 8'h00, 4'd11}, // R11 special mask on
    '{OP_CHK, 8'h00, 8'h01, 4'd11},
    '{OP_WR0, 8'h48, 8'h00, 4'd11}, // R11 special mask off
    '{OP_CHK, 8'h00, 8'h00, 4'd11}
  };

  logic       clk;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       wr_en;
  logic       rd_en;
  logic       addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       ack;
  logic [7:0] ack_vec;
  logic       int_req;

  int checks;
  int fails;
  bit done;

  intc_cmd_seq u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .ack     (ack),
    .ack_vec (ack_vec),
    .int_req (int_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input int r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [7:0] d, input logic [7:0] e, input int r);
    case (op)
      OP_IRQ: irq_in = d;
      OP_WR0: begin wr_en = 1'b1; addr = 1'b0; wdata = d; end
      OP_WR1: begin wr_en = 1'b1; addr = 1'b1; wdata = d; end
      OP_RD0: begin rd_en = 1'b1; addr = 1'b0; end
      OP_RD1: begin rd_en = 1'b1; addr = 1'b1; end
      OP_ACK: ack = 1'b1;
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    ack   = 1'b0;
    case (op)
      OP_RD0, OP_RD1: check(rdata == e, r, rdata, e);
      OP_ACK:         check(ack_vec == e, r, ack_vec, e);
      OP_CHK:         check(int_req == e[0], r, {7'd0, int_req}, e);
      default: ;
    endcase
  endtask

  initial begin
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    irq_in = '0;
    wr_en  = 1'b0;
    rd_en  = 1'b0;
    addr   = 1'b0;
    wdata  = '0;
    ack    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(int_req == 1'b0, 1, {7'd0, int_req}, 8'h00);
    check(ack_vec == 8'h00, 1, ack_vec, 8'h00);
    check(rdata == 8'h00, 1, rdata, 8'h00);
    step(OP_RD0, 8'h00, 8'h00, 1);  // R1 IRR empty and selected
    step(OP_RD1, 8'h00, 8'h00, 1);  // R1 mask clear

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].op, TBL[i].d, TBL[i].e, int'(TBL[i].r));
    end

    // R9 clean up after the special mask test
    step(OP_WR0, 8'h60, 8'h00, 9);
    step(OP_ACK, 8'h00, 8'h21, 6);
    step(OP_WR0, 8'h61, 8'h00, 9);
    step(OP_WR1, 8'h00, 8'h00, 4);

    // R7 automatic EOI, then rotation on automatic EOI
    step(OP_WR0, 8'h11, 8'h00, 7);
    step(OP_WR1, 8'h40, 8'h00, 7);
    step(OP_WR1, 8'h00, 8'h00, 7);
    step(OP_WR1, 8'h02, 8'h00, 7);
    step(OP_IRQ, 8'h00, 8'h00, 7);
    step(OP_IRQ, 8'h40, 8'h00, 7);
    step(OP_ACK, 8'h00, 8'h46, 7);
    step(OP_WR0, 8'h0B, 8'h00, 7);
    step(OP_RD0, 8'h00, 8'h00, 7);
    step(OP_WR0, 8'h80, 8'h00, 7);
    step(OP_IRQ, 8'h42, 8'h00, 7);
    step(OP_ACK, 8'h00, 8'h41, 7);
    step(OP_IRQ, 8'h47, 8'h00, 7);
    step(OP_ACK, 8'h00, 8'h42, 7);  // R7 offset 2 favours line 2
    step(OP_ACK, 8'h00, 8'h40, 7);
    step(OP_WR0, 8'h00, 8'h00, 7);

    // R12 nested mode lets the nest line interrupt itself
    step(OP_WR0, 8'h11, 8'h00, 12);
    step(OP_WR1, 8'h08, 8'h00, 12);
    step(OP_WR1, 8'h00, 8'h00, 12);
    step(OP_WR1, 8'h10, 8'h00, 12);
    step(OP_IRQ, 8'h00, 8'h00, 12);
    step(OP_IRQ, 8'h04, 8'h00, 12);
    step(OP_ACK, 8'h00, 8'h0A, 12);
    step(OP_IRQ, 8'h00, 8'h00, 12);
    step(OP_IRQ, 8'h04, 8'h00, 12);
    step(OP_CHK, 8'h00, 8'h01, 12);
    step(OP_WR0, 8'h10, 8'h00, 12);  // three-word init clears nested mode
    step(OP_WR1, 8'h08, 8'h00, 12);
    step(OP_WR1, 8'h00, 8'h00, 12);
    step(OP_CHK, 8'h00, 8'h00, 12);
    step(OP_WR1, 8'h33, 8'h00, 3);   // R3 back in normal mode
    step(OP_RD1, 8'h00, 8'h33, 3);
    step(OP_WR1, 8'h00, 8'h00, 3);

    // R6 spurious acknowledge
    step(OP_WR0, 8'h62, 8'h00, 6);
    step(OP_ACK, 8'h00, 8'h0A, 6);
    step(OP_WR0, 8'h62, 8'h00, 6);
    step(OP_ACK, 8'h00, 8'h0F, 6);
    step(OP_WR0, 8'h0B, 8'h00, 6);
    step(OP_RD0, 8'h00, 8'h00, 6);

    // R1 reset in mid-run
    step(OP_WR1, 8'h77, 8'h00, 1);
    step(OP_IRQ, 8'h00, 8'h00, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(int_req == 1'b0, 1, {7'd0, int_req}, 8'h00);
    step(OP_RD1, 8'h00, 8'h00, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule